// File: doc/BRIEF.md
# Two-Wire Command Slave for a Dual 64-Tap Digital Potentiometer

This block sits between a two-wire serial bus and the register bank of a dual 64-tap digital potentiometer. It watches the bus clock and data lines, oversampled by a fast system clock. Both lines pass through synchronizers and a glitch filter. The block then picks out start and stop conditions and shifts in bytes.

When the first byte carries the fixed type identifier 0101 followed by the four strapped address bits, the block acknowledges it. It then decodes an instruction byte that names an operation, a potentiometer and one of four data registers. Depending on the operation, the transaction finishes in one of four ways:
- after the instruction byte;
- after a third data byte written by the master;
- after a data byte returned to the master;
- in an open-ended stepping phase, where every clock pulse moves the selected wiper by one tap.

The block drives the bus only through an open-drain pull-down enable. It hands completed commands to the register bank as a one-cycle strobe with fields, or as single step pulses. While the bank reports a nonvolatile write in progress, the block ignores its own address. A master can therefore poll with start plus address until an acknowledge comes back.

Top module: `dpot_serial_slave`

## Requirements
- R1: A start condition (SDA falling while SCL high) restarts address reception from any state, even in the middle of a byte. A stop condition (SDA rising while SCL high) returns the block to idle. Bytes clocked without a preceding start are never acknowledged.
- R2: The block acknowledges the first byte, pulling SDA low for the ninth clock, only when the byte is 0101 followed by addr_i[3:0], MSB first. On any mismatch it stays silent until the next start.
- R3: The instruction byte is always acknowledged. Its bits [7:4] are the opcode, [3:2] the data-register select and [0] the pot select. These fields appear on cmd_op_o, cmd_reg_o and cmd_pot_o once the byte is received.
- R4: Opcodes 1010 (write wiper) and 1100 (write data register) take a third byte, which is acknowledged. After that acknowledge, cmd_valid_o pulses for one cycle with cmd_wdata_o equal to the byte's low six bits.
- R5: Opcodes 1101, 1110, 0001 and 1000 (single and global transfers) pulse cmd_valid_o once after the instruction acknowledge and take no data byte.
- R6: Opcodes 1001 (read wiper) and 1011 (read data register) return the byte {2'b00, rd_data_i}, MSB first. rd_data_i is captured at the end of the instruction byte. SDA is released for the master's acknowledge bit, and no cmd_valid_o pulse is given.
- R7: While nv_busy_i is high, a matching address is not acknowledged. Once nv_busy_i is low, it is acknowledged again.
- R8: After opcode 0010 is acknowledged, every SCL high pulse until the next start or stop gives one step_o pulse, including the pulse that carries the stop. step_up_o equals SDA during that pulse (1 toward the high end, 0 toward the low end).
- R9: Opcodes outside the nine defined ones are acknowledged but give no cmd_valid_o and no step_o.
- R10: The SDA drive enable changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_i | input | 4 | Strapped device address bits |
| nv_busy_i | input | 1 | Register bank busy with a nonvolatile write |
| rd_data_i | input | 6 | Read data from the bank for the selected register |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cmd_valid_o | output | 1 | One-cycle strobe for a write or transfer command |
| cmd_op_o | output | 4 | Decoded opcode |
| cmd_pot_o | output | 1 | Pot select |
| cmd_reg_o | output | 2 | Data-register select |
| cmd_wdata_o | output | 6 | Write data for write commands |
| step_o | output | 1 | One-cycle wiper step pulse |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
The in-design assertions watch, on every cycle, several protocol rules:
- the drive enable moves only while SCL is low;
- no address acknowledge begins while the bank is busy or the identifier bits differ;
- step pulses occur only in the stepping phase;
- command strobes carry only write or transfer opcodes;
- SDA is free during the master's read acknowledge.

Only the bench scenarios show the end-to-end results. These cover the exact fields and data values delivered per opcode and the byte returned on reads. They also cover the up and down step counts, recovery from a start inside a byte, and the return of the acknowledge once the busy flag drops.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam logic [3:0] DEV_ID = 4'b0101;

  localparam logic [3:0] OP_RD_WIPER          = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER          = 4'b1010;
  localparam logic [3:0] OP_RD_DREG           = 4'b1011;
  localparam logic [3:0] OP_WR_DREG           = 4'b1100;
  localparam logic [3:0] OP_DREG_TO_WIPER     = 4'b1101;
  localparam logic [3:0] OP_WIPER_TO_DREG     = 4'b1110;
  localparam logic [3:0] OP_ALL_DREG_TO_WIPER = 4'b0001;
  localparam logic [3:0] OP_ALL_WIPER_TO_DREG = 4'b1000;
  localparam logic [3:0] OP_STEP              = 4'b0010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_RX, PH_TX, PH_STEP
  } phase_e;

  typedef enum logic [2:0] {
    CL_NONE, CL_READ, CL_WRITE, CL_XFER, CL_STEP
  } op_class_e;

  function automatic op_class_e classify(input logic [3:0] op);
    case (op)
      OP_RD_WIPER, OP_RD_DREG:                      return CL_READ;
      OP_WR_WIPER, OP_WR_DREG:                      return CL_WRITE;
      OP_DREG_TO_WIPER, OP_WIPER_TO_DREG,
      OP_ALL_DREG_TO_WIPER, OP_ALL_WIPER_TO_DREG:   return CL_XFER;
      OP_STEP:                                      return CL_STEP;
      default:                                      return CL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dps_deglitch.sv
module dps_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (sync_q[1] != lvl_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) lvl_d = sync_q[1];
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign line_o = lvl_q;
endmodule

// File: rtl/dps_bus_events.sv
module dps_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_lvl,
  output logic sda_lvl
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_lvl  = scl_q;
  assign sda_lvl  = sda_q;
endmodule

// File: rtl/dps_cmd_engine.sv
module dps_cmd_engine
  import dps_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic [3:0]        addr_i,
  input  logic              nv_busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic              cmd_pot_o,
  output logic [1:0]        cmd_reg_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              step_o,
  output logic              step_up_o
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] BYTE_END = 4'd9;

  phase_e            ph_q, ph_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d;
  logic              oe_q, oe_d;
  logic [3:0]        op_q, op_d;
  logic              pot_q, pot_d;
  logic [1:0]        reg_q, reg_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              vld_q, vld_d, stp_q, stp_d, up_q, up_d;
  logic [7:0]        rd_byte;

  assign rd_byte = 8'(rd_data_i);

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; sh_d = sh_q; tx_d = tx_q; oe_d = oe_q;
    op_d = op_q; pot_d = pot_q; reg_d = reg_q; wd_d = wd_q;
    vld_d = 1'b0; stp_d = 1'b0; up_d = up_q;
    if (start_ev) begin
      ph_d = PH_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_ev) begin
      ph_d = PH_IDLE; oe_d = 1'b0;
    end else if (ph_q != PH_IDLE) begin
      if (scl_rise) begin
        if (ph_q == PH_STEP) begin
          stp_d = 1'b1; up_d = sda_lvl;
        end else if (cnt_q < ACK_SLOT) begin
          sh_d = {sh_q[6:0], sda_lvl}; cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == ACK_SLOT) begin
          cnt_d = BYTE_END;
        end
      end else if (scl_fall && ph_q != PH_STEP) begin
        if (cnt_q == ACK_SLOT) begin
          case (ph_q)
            PH_ADDR: begin
              if (sh_q == {DEV_ID, addr_i} && !nv_busy_i) oe_d = 1'b1;
              else ph_d = PH_IDLE;
            end
            PH_INSTR: begin
              oe_d = 1'b1; op_d = sh_q[7:4]; reg_d = sh_q[3:2]; pot_d = sh_q[0];
            end
            PH_RX: begin
              oe_d = 1'b1; wd_d = sh_q[DATA_W-1:0];
            end
            default: oe_d = 1'b0;
          endcase
        end else if (cnt_q == BYTE_END) begin
          cnt_d = '0; oe_d = 1'b0;
          case (ph_q)
            PH_ADDR:  ph_d = PH_INSTR;
            PH_INSTR: begin
              case (classify(op_q))
                CL_READ: begin
                  ph_d = PH_TX; oe_d = ~rd_byte[7]; tx_d = {rd_byte[6:0], 1'b1};
                end
                CL_WRITE: ph_d = PH_RX;
                CL_XFER:  begin ph_d = PH_IDLE; vld_d = 1'b1; end
                CL_STEP:  ph_d = PH_STEP;
                default:  ph_d = PH_IDLE;
              endcase
            end
            PH_RX:   begin ph_d = PH_IDLE; vld_d = 1'b1; end
            default: ph_d = PH_IDLE;
          endcase
        end else if (ph_q == PH_TX) begin
          oe_d = ~tx_q[7]; tx_d = {tx_q[6:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; oe_q <= 1'b0;
      op_q <= '0; pot_q <= 1'b0; reg_q <= '0; wd_q <= '0;
      vld_q <= 1'b0; stp_q <= 1'b0; up_q <= 1'b0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d; tx_q <= tx_d; oe_q <= oe_d;
      op_q <= op_d; pot_q <= pot_d; reg_q <= reg_d; wd_q <= wd_d;
      vld_q <= vld_d; stp_q <= stp_d; up_q <= up_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign cmd_valid_o = vld_q;
  assign cmd_op_o    = op_q;
  assign cmd_pot_o   = pot_q;
  assign cmd_reg_o   = reg_q;
  assign cmd_wdata_o = wd_q;
  assign step_o      = stp_q;
  assign step_up_o   = up_q;

  // R10
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_lvl);
  // R2
  addr_ack_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR && oe_q) |-> (sh_q[7:4] == DEV_ID));
  // R7
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && ph_q == PH_ADDR) |-> !$past(nv_busy_i));
  // R8
  step_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stp_q |-> (ph_q == PH_STEP));
  // R9
  strobe_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (classify(op_q) == CL_WRITE || classify(op_q) == CL_XFER));
  // R6
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TX && cnt_q == BYTE_END) |-> !oe_q);
endmodule

// File: rtl/dpot_serial_slave.sv
module dpot_serial_slave #(
  parameter int FILT_LEN = 3,
  parameter int DATA_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [3:0]        addr_i,
  input  logic              nv_busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic              cmd_pot_o,
  output logic [1:0]        cmd_reg_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              step_o,
  output logic              step_up_o
);
  localparam int N_LINES = 2;

  logic [1:0]         rst_sync_q;
  logic               irst_n;
  logic [N_LINES-1:0] raw, filt;
  logic scl_rise, scl_fall, start_ev, stop_ev, scl_lvl, sda_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign irst_n = rst_sync_q[1];

  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    dps_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(irst_n), .line_i(raw[i]), .line_o(filt[i])
    );
  end

  dps_bus_events u_evt (
    .clk(clk), .rst_n(irst_n), .scl_f(filt[1]), .sda_f(filt[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
  );

  dps_cmd_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(irst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .addr_i(addr_i), .nv_busy_i(nv_busy_i), .rd_data_i(rd_data_i),
    .sda_oe_o(sda_oe_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_pot_o(cmd_pot_o), .cmd_reg_o(cmd_reg_o), .cmd_wdata_o(cmd_wdata_o),
    .step_o(step_o), .step_up_o(step_up_o)
  );
endmodule

// File: tb/sim_dpot_serial_slave.sv
module sim_dpot_serial_slave;
  localparam int Q = 12;

  logic clk, rst_n, scl_m, sda_m, nv_busy, sda_bus;
  logic [3:0] dev_addr;
  logic [5:0] rd_val;
  logic sda_oe, vld, pot, step, step_up;
  logic [3:0] op;
  logic [1:0] rg;
  logic [5:0] wd;

  int n_chk, n_fail, n_strobe, n_up, n_dn;
  logic [3:0] s_op; logic s_pot; logic [1:0] s_reg; logic [5:0] s_wd;
  bit done;

  assign sda_bus = sda_m & ~sda_oe;

  dpot_serial_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .addr_i(dev_addr),
    .nv_busy_i(nv_busy), .rd_data_i(rd_val), .sda_oe_o(sda_oe), .cmd_valid_o(vld),
    .cmd_op_o(op), .cmd_pot_o(pot), .cmd_reg_o(rg), .cmd_wdata_o(wd),
    .step_o(step), .step_up_o(step_up)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (vld) begin n_strobe++; s_op = op; s_pot = pot; s_reg = rg; s_wd = wd; end
    if (step) begin if (step_up) n_up++; else n_dn++; end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected behaviour class: 0 none, 1 read, 2 write, 3 transfer, 4 step
  function automatic int exp_kind(input logic [3:0] o);
    case (o)
      4'b1001, 4'b1011: return 1;
      4'b1010, 4'b1100: return 2;
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return 3;
      4'b0010: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic do_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask
  task automatic do_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic rbyte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    end
    send_bit(1'b1);
  endtask

  task automatic do_cmd(input logic [3:0] o, input logic [1:0] r, input logic p,
                        input logic [5:0] d, input logic [5:0] rv);
    logic a; logic [7:0] rb; int k;
    k = exp_kind(o);
    rd_val = rv; n_strobe = 0;
    do_start;
    wbyte({4'b0101, dev_addr}, a); check("R2 addr ack", a, 1);
    wbyte({o, r, 1'b0, p}, a);     check("R3 instr ack", a, 1);
    if (k == 2) begin wbyte({2'b00, d}, a); check("R4 data ack", a, 1); end
    if (k == 1) begin rbyte(rb); check("R6 read byte", rb, {2'b00, rv}); end
    do_stop; tick(4);
    check("R4/R5 strobe count R9", n_strobe, (k == 2 || k == 3) ? 1 : 0);
    if (k == 2 || k == 3) begin
      check("R3 strobe op", s_op, o);
      check("R3 strobe reg", s_reg, r);
      check("R3 strobe pot", s_pot, p);
      if (k == 2) check("R4 wdata", s_wd, d);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a; int ones, nb; logic [3:0] ro; logic [7:0] rb;
    logic [3:0] xf [4];
    xf[0] = 4'b1101; xf[1] = 4'b1110; xf[2] = 4'b0001; xf[3] = 4'b1000;
    n_chk = 0; n_fail = 0; n_strobe = 0; n_up = 0; n_dn = 0; done = 0;
    void'($urandom(32'd2024));
    scl_m = 1'b1; sda_m = 1'b1; nv_busy = 1'b0; dev_addr = 4'hA; rd_val = '0;
    rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(10);
    check("R1 reset oe", sda_oe, 0);
    check("R1 reset strobe", vld, 0);
    check("R8 reset step", step, 0);

    // directed commands
    do_cmd(4'b1010, 2'd0, 1'b1, 6'h2D, 6'h00);
    do_cmd(4'b1100, 2'd3, 1'b0, 6'h3F, 6'h00);
    do_cmd(4'b1011, 2'd2, 1'b1, 6'h00, 6'h15);
    do_cmd(4'b1001, 2'd0, 1'b0, 6'h00, 6'h3E);
    do_cmd(4'b0001, 2'd1, 1'b0, 6'h00, 6'h00);
    do_cmd(4'b0100, 2'd1, 1'b1, 6'h00, 6'h00); // R9 undefined opcode
    do_cmd(4'b1111, 2'd2, 1'b0, 6'h00, 6'h00); // R9 undefined opcode

    // R2 mismatch
    do_start; wbyte({4'b0101, dev_addr ^ 4'b0100}, a); check("R2 mismatch ack", a, 0);
    wbyte(8'h1A, a); check("R2 silent after mismatch", a, 0); do_stop;
    do_start; wbyte({4'b0111, dev_addr}, a); check("R2 id mismatch", a, 0); do_stop;

    // R1 no start, no answer
    wbyte({4'b0101, dev_addr}, a); check("R1 no start", a, 0); do_stop;

    // R7 busy polling
    nv_busy = 1'b1;
    do_start; wbyte({4'b0101, dev_addr}, a); check("R7 busy no ack", a, 0); do_stop;
    nv_busy = 1'b0;
    do_start; wbyte({4'b0101, dev_addr}, a); check("R7 ack after busy", a, 1); do_stop;

    // R1 start inside a byte
    n_strobe = 0;
    do_start; send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_start;
    wbyte({4'b0101, dev_addr}, a); check("R1 restart addr ack", a, 1);
    wbyte({4'b1110, 2'd2, 1'b0, 1'b1}, a); check("R1 restart instr ack", a, 1);
    do_stop; tick(4);
    check("R1 strobe after restart", n_strobe, 1);
    check("R5 op after restart", s_op, 4'b1110);

    // R8 stepping
    for (int t = 0; t < 2; t++) begin
      n_up = 0; n_dn = 0; n_strobe = 0; ones = 0;
      nb = 4 + int'($urandom % 8);
      do_start; wbyte({4'b0101, dev_addr}, a);
      wbyte({4'b0010, 2'd0, 1'b0, t[0]}, a); check("R8 step instr ack", a, 1);
      check("R3 step pot", pot, t);
      for (int i = 0; i < nb; i++) begin
        logic b; b = $urandom % 2; ones += b; send_bit(b);
      end
      do_stop; tick(4);
      check("R8 up steps", n_up, ones);
      check("R8 down steps", n_dn, nb - ones + 1);
      check("R8 no strobe", n_strobe, 0);
    end
    // R8 no step after stop
    n_up = 0; n_dn = 0;
    send_bit(1'b1); send_bit(1'b0); do_stop;
    check("R8 idle no step", n_up + n_dn, 0);

    // random mix
    for (int it = 0; it < 10; it++) begin
      int kind; kind = $urandom % 4;
      case (kind)
        0: ro = 4'b1010;
        1: ro = 4'b1100;
        2: ro = ($urandom % 2) ? 4'b1001 : 4'b1011;
        default: ro = xf[$urandom % 4];
      endcase
      do_cmd(ro, 2'($urandom), 1'($urandom), 6'($urandom), 6'($urandom));
    end

    // R10 read byte with alternating pattern
    rd_val = 6'h2A; n_strobe = 0;
    do_start; wbyte({4'b0101, dev_addr}, a); wbyte({4'b1001, 2'd0, 1'b0, 1'b1}, a);
    rbyte(rb); check("R6 R10 alternating read", rb, 8'h2A); do_stop;
    check("R6 read no strobe", n_strobe, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule